// File: doc/BRIEF.md
# Signed-Digit Window Partitioner

This block takes an unsigned multiplier and rewrites it as a canonical signed-digit number. Every digit of that number is -1, 0 or +1, and no two nonzero digits are neighbours. The block then walks the digits from the least significant end and cuts them into windows. A run of zero digits always becomes one window, however long the run is. A nonzero window opens on a nonzero digit and spans at most `WIN_D` digits. Zero digits at its top are trimmed off, so the window also ends on a nonzero digit.

Each window is offered as one descriptor on a valid/ready stream. A descriptor has a length, a signed value in two's complement on `WIN_D+1` bits, a nonzero flag and a last flag. A serial multiplier that consumes the stream can handle a whole zero run in one step. It needs one step per nonzero window instead of one per bit. The block also counts the windows emitted since the last start. The recoded number has `N_BITS+1` digits, because the canonical form can be one digit longer than the binary input.

Top module: `naf_window_splitter`

## Requirements
- R1: While reset is held, and after it is released, `win_valid` and `busy` are low and `win_count` is zero.
- R2: A `start` pulse while the block is idle captures `mult_in`, and the first descriptor is valid on the next cycle. A `start` while `busy` is high is ignored and leaves the descriptor stream unchanged.
- R3: The recoding has `N_BITS+1` digits, each -1, 0 or +1. No two adjacent digits are both nonzero, and the digit sum weighted by powers of two equals the input. This is the unique non-adjacent form.
- R4: Windows come out in order from the least significant digit upward. The window lengths add up to `N_BITS+1`, and the sum of each value shifted left by its window's digit offset equals the input.
- R5: A zero window covers a whole maximal run of zero digits, of any length, and has value 0 and `win_nz` low. A zero window is never followed by another zero window.
- R6: A nonzero window has length 1 to `WIN_D`, and both its lowest and its highest digit are nonzero, so its value is odd. The value is its weighted digit sum in two's complement on `WIN_D+1` bits.
- R7: While `win_valid` is high and `win_ready` is low, every descriptor field holds steady. Each accepted handshake moves the stream on by exactly one window.
- R8: `win_last` is high only on the window that reaches the top digit. After that window is accepted, `win_valid` and `busy` are low on the next cycle.
- R9: `win_count` is cleared by an accepted start, rises by one on every accepted descriptor, and holds its value after the last one.
- R10: An input of zero gives a single zero window of length `N_BITS+1` with `win_last` high.
- R11: An all-ones input gives a -1 window of length 1, then a zero window of length `N_BITS-1`, then a +1 window of length 1 marked last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin partitioning `mult_in` (taken only when idle) |
| mult_in | input | N_BITS | Unsigned multiplier |
| busy | output | 1 | A partition is in progress |
| win_valid | output | 1 | Descriptor on the window outputs is valid |
| win_ready | input | 1 | Consumer accepts the descriptor |
| win_len | output | $clog2(N_BITS+2) | Window length in digits |
| win_val | output | WIN_D+1 | Window value, two's complement |
| win_nz | output | 1 | Window is nonzero |
| win_last | output | 1 | Window is the final one |
| win_count | output | $clog2(N_BITS+2) | Windows accepted since start |

## Verification
The hardest case to reach from the ports is a `start` that arrives while a descriptor is stalled mid-stream. The risk there is that the block silently reloads and the visible fields change. The bench holds `win_ready` low for varying stretches and pulses `start` with the inverted multiplier during those stalls. It then checks every later window against its own recoding of the original value. Inputs with a carry running out past the top bit (all ones) and a zero run that spans most of the word exercise the extra digit and zero windows of unlimited length.

// File: rtl/naf_pkg.sv
package naf_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } split_state_t;
endpackage

// File: rtl/naf_recoder.sv
module naf_recoder #(
  parameter int N_BITS = 16,
  localparam int ND = N_BITS + 1
) (
  input  logic [N_BITS-1:0] value,
  output logic [ND-1:0]     dig_pos,
  output logic [ND-1:0]     dig_neg
);
  // Carry rule: an odd partial (bit+carry) whose next bit is set becomes -1 with carry.
  function automatic logic [2*ND-1:0] recode(input logic [N_BITS-1:0] v);
    logic [ND-1:0] p;
    logic [ND-1:0] n;
    logic          c;
    logic          b;
    logic          nb;
    p = '0;
    n = '0;
    c = 1'b0;
    for (int i = 0; i < ND; i++) begin
      b  = (i < N_BITS) ? v[i] : 1'b0;
      nb = (i + 1 < N_BITS) ? v[i+1] : 1'b0;
      if (b ^ c) begin
        if (nb) begin
          n[i] = 1'b1;
          c    = 1'b1;
        end else begin
          p[i] = 1'b1;
          c    = 1'b0;
        end
      end else begin
        c = b & c;
      end
    end
    return {p, n};
  endfunction

  always_comb begin
    {dig_pos, dig_neg} = recode(value);
  end
endmodule

// File: rtl/naf_window_pick.sv
module naf_window_pick #(
  parameter int ND    = 17,
  parameter int WIN_D = 4,
  localparam int LW   = $clog2(ND + 1)
) (
  input  logic [ND-1:0]  dig_pos,
  input  logic [ND-1:0]  dig_neg,
  input  logic [LW-1:0]  remain,
  output logic [LW-1:0]  pick_len,
  output logic [WIN_D:0] pick_val,
  output logic           pick_nz,
  output logic           pick_last
);
  logic [ND-1:0] nzmap;
  logic [LW-1:0] first_nz;
  logic          found;
  logic [LW-1:0] top_idx;
  logic [WIN_D:0] acc;

  assign nzmap = dig_pos | dig_neg;

  // Offset of the lowest nonzero digit, or the remaining count if none.
  always_comb begin
    first_nz = remain;
    found    = 1'b0;
    for (int i = 0; i < ND; i++) begin
      if (!found && nzmap[i]) begin
        first_nz = LW'(i);
        found    = 1'b1;
      end
    end
  end

  // Nonzero window: highest nonzero digit among the lowest WIN_D, weighted sum mod 2^(WIN_D+1).
  always_comb begin
    top_idx = '0;
    acc     = '0;
    for (int j = 0; j < WIN_D; j++) begin
      if (nzmap[j]) top_idx = LW'(j);
      if (dig_pos[j]) acc = acc + ((WIN_D+1)'(1) << j);
      if (dig_neg[j]) acc = acc - ((WIN_D+1)'(1) << j);
    end
  end

  always_comb begin
    pick_nz   = nzmap[0];
    pick_len  = pick_nz ? (top_idx + LW'(1)) : first_nz;
    pick_val  = pick_nz ? acc : '0;
    pick_last = (pick_len == remain);
  end
endmodule

// File: rtl/naf_window_splitter.sv
module naf_window_splitter
  import naf_pkg::*;
#(
  parameter int N_BITS = 16,
  parameter int WIN_D  = 4,
  localparam int ND    = N_BITS + 1,
  localparam int LW    = $clog2(ND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_BITS-1:0] mult_in,
  output logic              busy,
  output logic              win_valid,
  input  logic              win_ready,
  output logic [LW-1:0]     win_len,
  output logic [WIN_D:0]    win_val,
  output logic              win_nz,
  output logic              win_last,
  output logic [LW-1:0]     win_count
);
  split_state_t  state_q;
  logic [ND-1:0] pos_q;
  logic [ND-1:0] neg_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] cnt_q;

  // Named internal events for the checker
  logic [ND-1:0] rec_pos;
  logic [ND-1:0] rec_neg;
  logic          start_take;
  logic          win_fire;

  naf_recoder #(.N_BITS(N_BITS)) u_rec (
    .value   (mult_in),
    .dig_pos (rec_pos),
    .dig_neg (rec_neg)
  );

  naf_window_pick #(.ND(ND), .WIN_D(WIN_D)) u_pick (
    .dig_pos   (pos_q),
    .dig_neg   (neg_q),
    .remain    (rem_q),
    .pick_len  (win_len),
    .pick_val  (win_val),
    .pick_nz   (win_nz),
    .pick_last (win_last)
  );

  assign busy       = (state_q == ST_EMIT);
  assign win_valid  = busy;
  assign start_take = start && (state_q == ST_IDLE);
  assign win_fire   = win_valid && win_ready;
  assign win_count  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      neg_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
    end else if (start_take) begin
      state_q <= ST_EMIT;
      pos_q   <= rec_pos;
      neg_q   <= rec_neg;
      rem_q   <= LW'(ND);
      cnt_q   <= '0;
    end else if (win_fire) begin
      pos_q <= pos_q >> win_len;
      neg_q <= neg_q >> win_len;
      rem_q <= rem_q - win_len;
      cnt_q <= cnt_q + LW'(1);
      if (win_last) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/naf_split_chk.sv
module naf_split_chk #(
  parameter int N_BITS = 16,
  parameter int WIN_D  = 4,
  localparam int ND    = N_BITS + 1,
  localparam int LW    = $clog2(ND + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           win_valid,
  input logic           win_ready,
  input logic [LW-1:0]  win_len,
  input logic [WIN_D:0] win_val,
  input logic           win_nz,
  input logic           win_last,
  input logic [LW-1:0]  win_count,
  input logic           win_fire,
  input logic [ND-1:0]  rec_pos,
  input logic [ND-1:0]  rec_neg
);
  // R3
  naf_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((rec_pos | rec_neg) & ((rec_pos | rec_neg) >> 1)) == '0) && ((rec_pos & rec_neg) == '0)));

  // R7
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_ready) |=> (win_valid && $stable(win_len) && $stable(win_val)
                                   && $stable(win_nz) && $stable(win_last)));

  // R6
  nz_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_nz) |-> (win_len >= LW'(1) && win_len <= LW'(WIN_D) && win_val[0]));

  // R5
  zero_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_nz) |-> (win_val == '0 && win_len != '0));

  // R5
  zero_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_fire && !win_nz && !win_last) |=> (win_valid && win_nz));

  // R8
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_fire && win_last) |=> (!win_valid && !busy));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_fire |=> (win_count == $past(win_count) + LW'(1)));
endmodule

bind naf_window_splitter naf_split_chk #(.N_BITS(N_BITS), .WIN_D(WIN_D)) u_chk (.*);

// File: tb/sim_naf_window_splitter.sv
module sim_naf_window_splitter;
  localparam int PERIOD = 10;
  localparam int NB = 16;
  localparam int D  = 4;
  localparam int ND = NB + 1;
  localparam int LW = $clog2(ND + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NB-1:0] mult_in = '0;
  logic          busy;
  logic          win_valid;
  logic          win_ready = 1'b0;
  logic [LW-1:0] win_len;
  logic [D:0]    win_val;
  logic          win_nz;
  logic          win_last;
  logic [LW-1:0] win_count;

  int tests = 0;
  int fails = 0;
  logic [ND-1:0] bpos;
  logic [ND-1:0] bneg;

  always #(PERIOD/2) clk = ~clk;

  naf_window_splitter #(.N_BITS(NB), .WIN_D(D)) u0 (
    .clk, .rst_n, .start, .mult_in, .busy, .win_valid, .win_ready,
    .win_len, .win_val, .win_nz, .win_last, .win_count
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench recoding: x with 3x, xor marks the digits that differ.
  task automatic bench_naf(input logic [NB-1:0] v);
    logic [NB+1:0] x;
    logic [NB+1:0] h;
    logic [NB+1:0] c;
    x = {2'b00, v};
    h = x * 3;
    c = h ^ x;
    bpos = ND'((h & c) >> 1);
    bneg = ND'((x & c) >> 1);
  endtask

  function automatic bit bdig_nz(input int idx);
    return (idx < ND) && (bpos[idx] || bneg[idx]);
  endfunction

  // stall_mode: 0 none, 1 stalls, 2 stalls plus start pulses while busy
  task automatic run_case(input logic [NB-1:0] v, input int stall_mode, input string tag);
    int off = 0;
    int doff = 0;
    int w = 0;
    int lensum = 0;
    longint acc = 0;
    bit fin = 0;
    bench_naf(v);
    @(negedge clk);
    start = 1'b1;
    mult_in = v;
    @(negedge clk);
    start = 1'b0;
    check(win_valid == 1'b1, {"R2 first valid ", tag}, win_valid, 1);
    while (!fin && w < 40) begin
      int elen = 0;
      longint ev = 0;
      bit enz;
      longint sv;
      enz = bdig_nz(off);
      if (enz) begin
        int top = 0;
        for (int j = 0; j < D; j++) begin
          if (bdig_nz(off + j)) begin
            top = j;
            ev = ev + (bpos[off+j] ? (64'sd1 <<< j) : -(64'sd1 <<< j));
          end
        end
        elen = top + 1;
      end else begin
        while (off + elen < ND && !bdig_nz(off + elen)) elen++;
      end
      for (int s = 0; s < ((stall_mode != 0) ? (w % 3) : 0); s++) begin
        win_ready = 1'b0;
        start = (stall_mode == 2);
        mult_in = ~v;
        @(negedge clk);
        start = 1'b0;
      end
      sv = $signed(win_val);
      check(win_valid == 1'b1, {"R7 valid held ", tag}, win_valid, 1);
      check(win_len == LW'(elen), {"R4 R5 R6 len ", tag}, win_len, elen);
      check(sv == ev, {"R6 value ", tag}, sv, ev);
      check(win_nz == enz, {"R5 R6 nz flag ", tag}, win_nz, enz);
      check(win_last == (off + elen == ND), {"R8 last ", tag}, win_last, (off + elen == ND));
      check(win_count == LW'(w), {"R9 count ", tag}, win_count, w);
      acc = acc + (sv <<< doff);
      doff = doff + int'(win_len);
      lensum = lensum + int'(win_len);
      fin = win_last;
      win_ready = 1'b1;
      @(negedge clk);
      win_ready = 1'b0;
      off = off + elen;
      w++;
    end
    check(win_valid == 1'b0 && busy == 1'b0, {"R8 idle after last ", tag}, {win_valid, busy}, 0);
    check(win_count == LW'(w), {"R9 count holds ", tag}, win_count, w);
    check(acc == longint'(v), {"R4 R3 reconstruct ", tag}, acc, v);
    check(lensum == ND, {"R4 length sum ", tag}, lensum, ND);
  endtask

  task automatic reset_case();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!win_valid && !busy && win_count == '0, "R1 in reset", {win_valid, busy, win_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!win_valid && !busy && win_count == '0, "R1 after reset", {win_valid, busy, win_count}, 0);
  endtask

  task automatic zero_case();
    run_case('0, 0, "R10 zero input");
  endtask

  task automatic ones_case();
    run_case('1, 1, "R11 all ones");
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    reset_case();
    zero_case();
    ones_case();
    run_case(16'h5555, 0, "R6 alternating");
    run_case(16'h8000, 1, "R5 long zero run");
    run_case(16'hB6DB, 2, "R2 R7 start while busy");
    run_case(16'h0001, 0, "R4 single bit");
    run_case(16'h7BEF, 2, "R3 carry chains");
    run_case(16'h2C3A, 1, "R4 mixed");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule